// File: doc/BRIEF.md
# Interrupt Context Frame Sequencer

This block performs the hardware half of taking an interrupt and coming back from it. When a source number is accepted, it writes the caller-saved register set to the current descending stack one word per cycle. It then fetches the handler address from the vector table, loads that address into the program counter and sets the link register to a reserved return token. Because the handler starts with the caller-saved registers already preserved, it can be an ordinary compiled routine.

When the handler later branches to the return token, the block does not load the token into the program counter. It reads the eight frame words back, restores the registers and the stack pointer, and the interrupted code resumes. A branch to any other address simply loads the program counter.

The block holds a small register file: r0, r1, r2, r3, r12, lr, pc, psr and the stack pointer. A write and read port lets surrounding logic set and observe these registers. The frame is kept 8-byte aligned: when the stack pointer is 4 modulo 8 on entry, one pad word is left above the frame, and a flag bit in the stacked status word records the padding. Instruction decode, interrupt prioritisation and the execution pipeline are outside the block.

Top module: `irqf_sequencer`

## Requirements
- R1: After reset, busy, mem_req and vec_req are low, and pc_o, lr_o, sp_o and all general registers read as zero.
- R2: An accepted entry writes eight words on eight consecutive cycles, one per cycle, at ascending addresses starting at the new stack pointer. The order is r0, r1, r2, r3, r12, lr, pc, psr.
- R3: On entry the stack pointer drops by 32 if it was a multiple of 8, and by 36 if it was 4 modulo 8. The stacked psr has bit 9 set exactly when padding was added, and the pad word in memory is left untouched.
- R4: After stacking, the block requests the vector at byte address 4 × (source + 16). pc then takes the returned word and lr becomes 0xFFFFFFFD.
- R5: busy is high for exactly 9 cycles after an entry is accepted (8 stores and 1 vector fetch) and for exactly 8 cycles after a return starts.
- R6: A return notification whose target is 0xFFFFFFFD reads the frame back and restores r0, r1, r2, r3, r12, lr, pc and psr. Bit 9 of the live psr is cleared.
- R7: At the end of a return the stack pointer equals the frame base plus 32, plus 4 more if bit 9 of the restored psr word was set.
- R8: While idle, a return notification with any other target loads that target into pc on the next cycle, with no memory traffic and no busy period.
- R9: While busy, entry requests, return notifications and register-port writes are ignored.
- R10: An entry whose source number is 48 or higher is ignored.
- R11: The register port uses select codes 0 to 7 for r0, r1, r2, r3, r12, lr, pc, psr and code 8 for the stack pointer. A write takes effect on the next cycle; reads are combinational, and unused codes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_valid | input | 1 | Interrupt source accepted this cycle |
| entry_src | input | SRC_W | Source number of the accepted interrupt |
| ret_valid | input | 1 | Return-branch notification |
| ret_target | input | 32 | Branch target address of the notification |
| rf_we | input | 1 | Register-port write enable |
| rf_wsel | input | 4 | Register-port write select |
| rf_wdata | input | 32 | Register-port write data |
| rf_rsel | input | 4 | Register-port read select |
| rf_rdata | output | 32 | Register-port read data |
| mem_req | output | 1 | Stack memory access this cycle |
| mem_we | output | 1 | Stack access is a write |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, same cycle |
| vec_req | output | 1 | Vector table lookup this cycle |
| vec_addr | output | 32 | Vector table byte address |
| vec_data | input | 32 | Vector table word, same cycle |
| pc_o | output | 32 | Current program counter |
| lr_o | output | 32 | Current link register |
| sp_o | output | 32 | Current stack pointer |
| busy | output | 1 | Sequencer is stacking, fetching or unstacking |

## Verification
The sweep crosses sources at both ends of the legal range with stack pointers of both alignments, and follows every entry with a full return. A design that got the alignment test wrong would produce a frame off by one word, overwrite the pad slot, or leave the stack pointer 4 bytes off after return. A wrong vector index shows up as a pc that differs from the arithmetic table value. A design that failed to clear or honour the pad flag would leave psr bit 9 set or mis-restore the stack pointer. Requests injected in the middle of a busy window, a branch target one below the return token, and source numbers 48 and 63 target designs that would accept work while busy, match the token loosely, or trust an out-of-range source.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;
  localparam int XLEN     = 32;
  localparam int NREG     = 8;
  localparam int BEAT_W   = 3;
  localparam int PAD_BIT  = 9;
  localparam logic [XLEN-1:0] EXC_RETURN = 32'hFFFF_FFFD;
  localparam logic [XLEN-1:0] PAD_MASK   = 32'h1 << PAD_BIT;
  localparam int IDX_LR   = 5;
  localparam int IDX_PC   = 6;
  localparam int IDX_PSR  = 7;
  localparam logic [3:0] SEL_SP = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2,
    ST_POP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irqf_frame_calc.sv
`timescale 1ns/1ps
module irqf_frame_calc
  import irqf_pkg::*;
(
  input  logic [XLEN-1:0] sp,
  input  logic            ret_pad,
  output logic            pad,
  output logic [XLEN-1:0] push_sp,
  output logic [XLEN-1:0] pop_sp
);
  localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(NREG * 4);
  localparam logic [XLEN-1:0] PAD_BYTES   = XLEN'(4);

  // frame stays 8-byte aligned; a stack pointer at 4 mod 8 costs one pad word
  assign pad     = sp[2];
  assign push_sp = sp - FRAME_BYTES - (pad ? PAD_BYTES : '0);
  assign pop_sp  = sp + FRAME_BYTES + (ret_pad ? PAD_BYTES : '0);
endmodule

// File: rtl/irqf_ctrl.sv
`timescale 1ns/1ps
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter int SRC_W   = 6,
  parameter int NUM_SRC = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_valid,
  input  logic [SRC_W-1:0]  entry_src,
  input  logic              ret_valid,
  input  logic [XLEN-1:0]   ret_target,
  input  logic              pad_in,
  output seq_state_e        state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              pad_o,
  output logic              start_entry,
  output logic              start_ret,
  output logic              plain_branch,
  output logic              last_beat
);
  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [SRC_W-1:0]  src_q;
  logic              pad_q;
  logic              idle, src_ok, is_token;

  assign idle         = (state_q == ST_IDLE);
  assign src_ok       = int'(entry_src) < NUM_SRC;
  assign is_token     = (ret_target == EXC_RETURN);
  assign start_entry  = idle && entry_valid && src_ok;
  assign start_ret    = idle && !start_entry && ret_valid && is_token;
  assign plain_branch = idle && !start_entry && ret_valid && !is_token;
  assign last_beat    = (beat_q == BEAT_W'(NREG - 1));

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (start_entry)    state_d = ST_PUSH;
        else if (start_ret) state_d = ST_POP;
      end
      ST_PUSH: begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_VEC;
      end
      ST_VEC: state_d = ST_IDLE;
      ST_POP: begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pad_q <= 1'b0;
    end else if (start_entry) begin
      src_q <= entry_src;
      pad_q <= pad_in;
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign src_o   = src_q;
  assign pad_o   = pad_q;
endmodule

// File: rtl/irqf_regfile.sv
`timescale 1ns/1ps
module irqf_regfile
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_we,
  input  logic [3:0]        ext_sel,
  input  logic [XLEN-1:0]   ext_wd,
  input  logic              seq_we,
  input  logic [BEAT_W-1:0] seq_sel,
  input  logic [XLEN-1:0]   seq_wd,
  input  logic              vec_load,
  input  logic [XLEN-1:0]   vec_pc,
  input  logic              br_load,
  input  logic [XLEN-1:0]   br_pc,
  input  logic              sp_we,
  input  logic [XLEN-1:0]   sp_wd,
  input  logic [3:0]        rd_sel,
  input  logic [BEAT_W-1:0] fr_sel,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   fr_data,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   lr_q,
  output logic [XLEN-1:0]   sp_q
);
  logic [XLEN-1:0] cur [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q, d;
    logic            en;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (ext_we && ext_sel == 4'(g)) begin
        en = 1'b1;
        d  = ext_wd;
      end
      if (seq_we && seq_sel == BEAT_W'(g)) begin
        en = 1'b1;
        d  = seq_wd;
      end
      if (g == IDX_PC && vec_load) begin
        en = 1'b1;
        d  = vec_pc;
      end
      if (g == IDX_PC && br_load) begin
        en = 1'b1;
        d  = br_pc;
      end
      if (g == IDX_LR && vec_load) begin
        en = 1'b1;
        d  = EXC_RETURN;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign cur[g] = q;
  end

  logic            sp_en;
  logic [XLEN-1:0] sp_d, sp_r;

  always_comb begin
    sp_en = sp_we | (ext_we && ext_sel == SEL_SP);
    sp_d  = sp_we ? sp_wd : ext_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_r <= '0;
    else if (sp_en) sp_r <= sp_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel < 4'(NREG))     rd_data = cur[rd_sel[BEAT_W-1:0]];
    else if (rd_sel == SEL_SP) rd_data = sp_r;
  end

  assign fr_data = cur[fr_sel];
  assign pc_q    = cur[IDX_PC];
  assign lr_q    = cur[IDX_LR];
  assign sp_q    = sp_r;
endmodule

// File: rtl/irqf_sequencer.sv
`timescale 1ns/1ps
module irqf_sequencer
  import irqf_pkg::*;
#(
  parameter int SRC_W   = 6,
  parameter int NUM_SRC = 48,
  parameter int VEC_SYS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_valid,
  input  logic [SRC_W-1:0] entry_src,
  input  logic             ret_valid,
  input  logic [31:0]      ret_target,
  input  logic             rf_we,
  input  logic [3:0]       rf_wsel,
  input  logic [31:0]      rf_wdata,
  input  logic [3:0]       rf_rsel,
  output logic [31:0]      rf_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             vec_req,
  output logic [31:0]      vec_addr,
  input  logic [31:0]      vec_data,
  output logic [31:0]      pc_o,
  output logic [31:0]      lr_o,
  output logic [31:0]      sp_o,
  output logic             busy
);
  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic [SRC_W-1:0]  src_q;
  logic              pad_now, pad_q;
  logic              start_entry, start_ret, plain_branch, last_beat;
  logic              in_push, in_pop;
  logic [XLEN-1:0]   push_sp, pop_sp, fr_data, sp_q, seq_wd, sp_wd;

  irqf_ctrl #(.SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .entry_src   (entry_src),
    .ret_valid   (ret_valid),
    .ret_target  (ret_target),
    .pad_in      (pad_now),
    .state_o     (state),
    .beat_o      (beat),
    .src_o       (src_q),
    .pad_o       (pad_q),
    .start_entry (start_entry),
    .start_ret   (start_ret),
    .plain_branch(plain_branch),
    .last_beat   (last_beat)
  );

  irqf_frame_calc u_calc (
    .sp     (sp_q),
    .ret_pad(mem_rdata[PAD_BIT]),
    .pad    (pad_now),
    .push_sp(push_sp),
    .pop_sp (pop_sp)
  );

  assign in_push = (state == ST_PUSH);
  assign in_pop  = (state == ST_POP);
  assign busy    = (state != ST_IDLE);

  // restored status word never keeps the pad flag live
  assign seq_wd = last_beat ? (mem_rdata & ~PAD_MASK) : mem_rdata;
  assign sp_wd  = start_entry ? push_sp : pop_sp;

  irqf_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_we  (rf_we && !busy),
    .ext_sel (rf_wsel),
    .ext_wd  (rf_wdata),
    .seq_we  (in_pop),
    .seq_sel (beat),
    .seq_wd  (seq_wd),
    .vec_load(state == ST_VEC),
    .vec_pc  (vec_data),
    .br_load (plain_branch),
    .br_pc   (ret_target),
    .sp_we   (start_entry || (in_pop && last_beat)),
    .sp_wd   (sp_wd),
    .rd_sel  (rf_rsel),
    .fr_sel  (beat),
    .rd_data (rf_rdata),
    .fr_data (fr_data),
    .pc_q    (pc_o),
    .lr_q    (lr_o),
    .sp_q    (sp_q)
  );

  // both stacking and unstacking walk upward from the frame base held in sp
  assign mem_req   = in_push || in_pop;
  assign mem_we    = in_push;
  assign mem_addr  = sp_q + {{(XLEN-BEAT_W-2){1'b0}}, beat, 2'b00};
  assign mem_wdata = last_beat ? ((fr_data & ~PAD_MASK) | (XLEN'(pad_q) << PAD_BIT))
                               : fr_data;

  assign vec_req  = (state == ST_VEC);
  assign vec_addr = ({{(XLEN-SRC_W){1'b0}}, src_q} + XLEN'(VEC_SYS)) << 2;
  assign sp_o     = sp_q;
endmodule

// File: rtl/irqf_sequencer_chk.sv
`timescale 1ns/1ps
module irqf_sequencer_chk #(
  parameter int SRC_W   = 6,
  parameter int NUM_SRC = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             entry_valid,
  input logic [SRC_W-1:0] entry_src,
  input logic             ret_valid,
  input logic [31:0]      ret_target,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic             pop_pad,
  input logic             vec_req,
  input logic [31:0]      vec_data,
  input logic [31:0]      pc_o,
  input logic [31:0]      lr_o,
  input logic [31:0]      sp_o,
  input logic             busy
);
  // R2
  frame_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && (mem_we == $past(mem_we))) |-> (mem_addr == $past(mem_addr) + 32'd4));

  // R3
  entry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mem_we) |-> ((sp_o == $past(sp_o) - 32'd32) || (sp_o == $past(sp_o) - 32'd36)));

  // R3
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (sp_o[2:0] == 3'b000));

  // R4
  vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> ((lr_o == 32'hFFFF_FFFD) && (pc_o == $past(vec_data))));

  // R5
  mem_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || vec_req) |-> busy);

  // R7
  return_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(mem_req && !mem_we)) |->
      (sp_o == $past(sp_o) + 32'd32 + ($past(pop_pad) ? 32'd4 : 32'd0)));

  // R8
  plain_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ret_valid && (ret_target != 32'hFFFF_FFFD) && !entry_valid) |=>
      ((pc_o == $past(ret_target)) && !busy));

  // R10
  bad_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && entry_valid && (int'(entry_src) >= NUM_SRC) && !ret_valid) |=> !busy);
endmodule

bind irqf_sequencer irqf_sequencer_chk #(.SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .entry_valid(entry_valid),
  .entry_src  (entry_src),
  .ret_valid  (ret_valid),
  .ret_target (ret_target),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .pop_pad    (mem_rdata[9]),
  .vec_req    (vec_req),
  .vec_data   (vec_data),
  .pc_o       (pc_o),
  .lr_o       (lr_o),
  .sp_o       (sp_o),
  .busy       (busy)
);

// File: tb/irqf_sequencer_test.sv
`timescale 1ns/1ps
module irqf_sequencer_test;
  localparam logic [31:0] TOKEN = 32'hFFFF_FFFD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_valid, ret_valid, rf_we;
  logic [5:0]  entry_src;
  logic [31:0] ret_target, rf_wdata, rf_rdata;
  logic [3:0]  rf_wsel, rf_rsel;
  logic        mem_req, mem_we, vec_req, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, vec_addr, vec_data, pc_o, lr_o, sp_o;
  logic [31:0] smem [64];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irqf_sequencer uut (
    .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_src(entry_src),
    .ret_valid(ret_valid), .ret_target(ret_target), .rf_we(rf_we), .rf_wsel(rf_wsel),
    .rf_wdata(rf_wdata), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vec_req(vec_req), .vec_addr(vec_addr), .vec_data(vec_data), .pc_o(pc_o),
    .lr_o(lr_o), .sp_o(sp_o), .busy(busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) smem[k] <= 32'hC0DE_0000 + 32'(k);
    end else if (mem_req && mem_we) begin
      smem[mem_addr[7:2]] <= mem_wdata;
    end
  end
  assign mem_rdata = smem[mem_addr[7:2]];
  assign vec_data  = 32'h8000_0000 | vec_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = sel; rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] sel, output logic [31:0] val);
    rf_rsel = sel;
    #1 val = rf_rdata;
  endtask

  // counts negedges with busy high after the accept edge; optional mid-window disturbance
  task automatic hold_busy(input bit disturb, output int n);
    @(negedge clk);
    entry_valid = 1'b0; ret_valid = 1'b0;
    n = 0;
    while (busy && n < 40) begin
      n++;
      if (disturb && n == 2) begin
        entry_valid = 1'b1; entry_src = 6'd3;
        rf_we = 1'b1; rf_wsel = 4'd0; rf_wdata = 32'hDEAD_BEEF;
        ret_valid = 1'b1; ret_target = TOKEN;
      end else begin
        entry_valid = 1'b0; rf_we = 1'b0; ret_valid = 1'b0;
      end
      @(negedge clk);
    end
    entry_valid = 1'b0; rf_we = 1'b0; ret_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i, input int c);
    if (i == 7) return 32'h2100_0000 | (32'(c) << 12);
    return (32'(i + 1) << 28) ^ (32'(c) << 4) ^ 32'h0000_0005;
  endfunction

  task automatic one_case(input int src, input logic [31:0] spv, input int c, input bit disturb);
    int n;
    logic [31:0] nsp, v, pad_prior, exp;
    bit pad;
    for (int i = 0; i < 8; i++) wreg(4'(i), pat(i, c));
    wreg(4'd8, spv);
    pad = spv[2];
    nsp = spv - (pad ? 32'd36 : 32'd32);
    pad_prior = smem[spv[7:2] - 6'd1];
    @(negedge clk);
    entry_valid = 1'b1; entry_src = 6'(src);
    hold_busy(disturb, n);
    chk("R5 entry busy cycles", 32'(n), 32'd9);
    chk("R3 sp after entry", sp_o, nsp);
    for (int i = 0; i < 8; i++) begin
      exp = (i == 7) ? (pat(7, c) | (32'(pad) << 9)) : pat(i, c);
      chk("R2 stacked word", smem[nsp[7:2] + 6'(i)], exp);
    end
    if (pad) chk("R3 pad word untouched", smem[spv[7:2] - 6'd1], pad_prior);
    chk("R4 pc from vector", pc_o, 32'h8000_0000 | 32'((src + 16) * 4));
    chk("R4 lr token", lr_o, TOKEN);
    if (disturb) begin
      rreg(4'd0, v);
      chk("R9 write while busy ignored", v, pat(0, c));
    end
    for (int i = 0; i < 8; i++) wreg(4'(i), 32'h5A5A_0200 ^ 32'(i));
    @(negedge clk);
    ret_valid = 1'b1; ret_target = TOKEN;
    hold_busy(1'b0, n);
    chk("R5 return busy cycles", 32'(n), 32'd8);
    for (int i = 0; i < 8; i++) begin
      rreg(4'(i), v);
      chk("R6 restored register", v, pat(i, c));
    end
    chk("R6 pc restored", pc_o, pat(6, c));
    chk("R7 sp after return", sp_o, spv);
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    int srcs [7] = '{0, 1, 15, 16, 31, 46, 47};
    logic [31:0] sps [4] = '{32'h80, 32'h84, 32'hF8, 32'hBC};
    logic [31:0] v, pc_keep;
    rst_n = 1'b0; entry_valid = 1'b0; entry_src = '0; ret_valid = 1'b0; ret_target = '0;
    rf_we = 1'b0; rf_wsel = '0; rf_wdata = '0; rf_rsel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy reset", 32'(busy), 32'd0);
    chk("R1 mem_req reset", 32'(mem_req), 32'd0);
    chk("R1 vec_req reset", 32'(vec_req), 32'd0);
    chk("R1 pc reset", pc_o, 32'd0);
    chk("R1 lr reset", lr_o, 32'd0);
    chk("R1 sp reset", sp_o, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rreg(4'(i), v);
      chk("R1 register reset", v, 32'd0);
    end

    // R11 register port encoding
    wreg(4'd8, 32'h0000_00A4);
    rreg(4'd8, v);
    chk("R11 sp select", v, 32'h0000_00A4);
    wreg(4'd4, 32'h1212_3434);
    rreg(4'd4, v);
    chk("R11 r12 select", v, 32'h1212_3434);
    rreg(4'd9, v);
    chk("R11 unused code reads zero", v, 32'd0);

    c = 0;
    foreach (srcs[s]) begin
      foreach (sps[p]) begin
        one_case(srcs[s], sps[p], c, c == 1);
        c++;
      end
    end

    // R8 ordinary branch, including a target adjacent to the token
    @(negedge clk);
    ret_valid = 1'b1; ret_target = 32'h0000_1234;
    @(negedge clk);
    ret_valid = 1'b0;
    chk("R8 pc after plain branch", pc_o, 32'h0000_1234);
    chk("R8 no busy on plain branch", 32'(busy), 32'd0);
    ret_valid = 1'b1; ret_target = 32'hFFFF_FFFC;
    @(negedge clk);
    ret_valid = 1'b0;
    chk("R8 near-token target loaded", pc_o, 32'hFFFF_FFFC);
    chk("R8 near-token not busy", 32'(busy), 32'd0);

    // R10 out-of-range sources
    pc_keep = pc_o;
    entry_valid = 1'b1; entry_src = 6'd48;
    @(negedge clk);
    entry_src = 6'd63;
    @(negedge clk);
    entry_valid = 1'b0;
    chk("R10 source 48/63 no busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R10 still idle", 32'(busy), 32'd0);
    chk("R10 pc unchanged", pc_o, pc_keep);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule